// File: doc/BRIEF.md
# Fixed-Point to Integer Rounder

This block turns a fixed-point word into a whole number. The input word has an integer field in its upper bits and a fraction field in its lower bits. The default layout is 24 integer bits over 8 fraction bits. A single mode pin tells the block how to read the word. In unsigned mode the word is a plain magnitude. In signed mode it is a two's complement number.

The block has only one rounding datapath. Every input is first widened by one bit into a signed form, chosen by the mode pin: zero fill for unsigned, sign copy for signed. That widened form covers both input ranges. Half of one integer step is then added, and the fraction field is dropped. The result is round-half-up, so ties go toward plus infinity for both signs. The output is a two's complement integer one bit wider than the input word, so that no input in either mode can overflow it. A parameter selects either a purely combinational output or one register stage.

Top module: `fxr_rounder`

## Requirements
- R1: The input `fx_in` is read with its upper INT_W bits as the integer field and its lower FRAC_W bits as the fraction; with a zero fraction the result is that integer field (for example 0x00001200 unsigned gives 18).
- R2: With `mode_signed` = 0 the input is an unsigned magnitude, zero-extended, and the result is never negative.
- R3: With `mode_signed` = 1 the input is two's complement, sign-extended from its top bit; a non-negative input gives a non-negative result.
- R4: A fraction at or above one half (0x80 in the default layout) rounds up toward plus infinity; a smaller fraction rounds down toward minus infinity; the rule is the same for negative inputs.
- R5: An input whose fraction field is zero is returned unchanged as an integer, in both modes.
- R6: `int_out` is a two's complement integer of INT_W+FRAC_W+1 bits; the largest unsigned input (0xFFFFFFFF) gives 16777216 with no overflow.
- R7: The signed corners give: 0xFFFFFF80 (-0.5) gives 0, 0x80000000 gives -8388608, 0x7FFFFFFF gives 8388608.
- R8: With REG_OUT = 0 the result appears in the same cycle as the input; with REG_OUT = 1 it appears one clock after the input is sampled.
- R9: With REG_OUT = 1, `int_out` is zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| mode_signed | input | 1 | 0: unsigned input, 1: two's complement input |
| fx_in | input | INT_W+FRAC_W | Fixed-point input word |
| int_out | output | INT_W+FRAC_W+1 | Rounded integer, two's complement |

## Verification
The bench builds a 4.4 configuration twice, once combinational and once registered. With only 8 input bits and two modes, every one of the 512 input codes is reachable, so each tie, every negative fraction and both range ends are swept. A third instance keeps the default 24.8 layout with the register. It takes the named corners: fractions 0x00, 0x7F, 0x80 and 0xFF, the range limits of both modes, and -0.5. Expected results come from integer arithmetic in the bench.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    // How the input word is interpreted.
    typedef enum logic {
        FXR_UNSIGNED = 1'b0,
        FXR_SIGNED   = 1'b1
    } fxr_mode_e;

    // The rounding step needs a half-step bit, so at least this many fraction bits.
    localparam int FXR_MIN_FRAC = 2;

endpackage

// File: rtl/fxr_widen.sv
// Widens the raw word by one bit into a signed form picked by the mode.
module fxr_widen
    import fxr_pkg::*;
#(
    parameter int IN_W = 32
) (
    input  logic [IN_W-1:0] raw,
    input  fxr_mode_e       mode,
    output logic [IN_W:0]   wide
);

    logic fill_bit;

    always_comb begin
        unique case (mode)
            FXR_SIGNED:   fill_bit = raw[IN_W-1];
            FXR_UNSIGNED: fill_bit = 1'b0;
            default:      fill_bit = 1'b0;
        endcase
        wide = {fill_bit, raw};
    end

endmodule

// File: rtl/fxr_round.sv
// Adds one half step and drops the fraction field (round half up).
module fxr_round #(
    parameter int IN_W   = 32,
    parameter int FRAC_W = 8,
    parameter int OUT_W  = IN_W + 1
) (
    input  logic [IN_W:0]      wide,
    output logic [OUT_W-1:0]   rounded
);

    localparam int SUM_W = IN_W + 2;
    localparam logic [SUM_W-1:0] HALF_STEP = SUM_W'(1) << (FRAC_W - 1);

    logic [SUM_W-1:0]        sum;
    logic signed [SUM_W-1:0] shifted;

    always_comb begin
        sum     = {wide[IN_W], wide} + HALF_STEP;
        shifted = $signed(sum) >>> FRAC_W;
        rounded = OUT_W'(shifted);
    end

endmodule

// File: rtl/fxr_stage.sv
// One register stage, two-process form.
module fxr_stage #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] value;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.value = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.value;

    // R8: once out of reset for two edges, the stage shows the previous input.
    p_reg_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q == $past(d)));

endmodule

// File: rtl/fxr_rounder.sv
module fxr_rounder
    import fxr_pkg::*;
#(
    parameter int INT_W   = 24,
    parameter int FRAC_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_signed,
    input  logic [INT_W+FRAC_W-1:0]       fx_in,
    output logic [INT_W+FRAC_W:0]         int_out
);

    localparam int IN_W  = INT_W + FRAC_W;
    localparam int OUT_W = IN_W + 1;

    logic [IN_W:0]    wide;
    logic [OUT_W-1:0] rounded;

    fxr_widen #(.IN_W(IN_W)) u_widen (
        .raw  (fx_in),
        .mode (fxr_mode_e'(mode_signed)),
        .wide (wide)
    );

    fxr_round #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_round (
        .wide    (wide),
        .rounded (rounded)
    );

    generate
        if (REG_OUT) begin : g_reg
            fxr_stage #(.W(OUT_W)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (rounded),
                .q     (int_out)
            );
        end else begin : g_comb
            assign int_out = rounded;
        end
    endgenerate

    initial begin
        if (FRAC_W < FXR_MIN_FRAC || INT_W < 1) begin
            $display("fxr_rounder: unsupported layout INT_W=%0d FRAC_W=%0d", INT_W, FRAC_W);
        end
    end

    // Floor of the widened value, used to bound the rounding step.
    logic [OUT_W-1:0] floor_chk;
    logic [OUT_W-1:0] int_field;
    always_comb begin
        floor_chk = OUT_W'($signed(wide) >>> FRAC_W);
        int_field = {{(FRAC_W+1){wide[IN_W]}}, wide[IN_W-1:FRAC_W]};
    end

    // R2: unsigned inputs never give a negative result.
    p_unsigned_nonneg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_signed |-> !rounded[OUT_W-1]);

    // R3: a non-negative signed input gives a non-negative result.
    p_signed_positive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_signed && !fx_in[IN_W-1]) |-> !rounded[OUT_W-1]);

    // R4: the result lies one step above the floor exactly when the fraction is at least one half.
    p_half_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rounded - floor_chk) == OUT_W'(fx_in[FRAC_W-1]));

    // R5: a zero fraction passes the integer field through.
    p_exact_integer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fx_in[FRAC_W-1:0] == '0) |-> (rounded == int_field));

endmodule

// File: tb/fxr_rounder_bench.sv
module fxr_rounder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int S_INT  = 4;
    localparam int S_FRAC = 4;
    localparam int S_IN   = S_INT + S_FRAC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Default layout, registered.
    logic        b_mode = 1'b0;
    logic [31:0] b_in   = '0;
    logic [32:0] b_out;

    // Small layout, combinational and registered.
    logic            s_mode = 1'b0;
    logic [S_IN-1:0] s_in   = '0;
    logic [S_IN:0]   s_comb;
    logic [S_IN:0]   s_reg;

    fxr_rounder u_fxr_rounder (
        .clk(clk), .rst_n(rst_n), .mode_signed(b_mode), .fx_in(b_in), .int_out(b_out)
    );

    fxr_rounder #(.INT_W(S_INT), .FRAC_W(S_FRAC), .REG_OUT(1'b0)) u_small_comb (
        .clk(clk), .rst_n(rst_n), .mode_signed(s_mode), .fx_in(s_in), .int_out(s_comb)
    );

    fxr_rounder #(.INT_W(S_INT), .FRAC_W(S_FRAC), .REG_OUT(1'b1)) u_small_reg (
        .clk(clk), .rst_n(rst_n), .mode_signed(s_mode), .fx_in(s_in), .int_out(s_reg)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Round half up computed with integer arithmetic.
    function automatic longint model(input longint raw, input bit sgn, input int total, input int fw);
        longint v;
        v = raw;
        if (sgn && ((raw >> (total - 1)) & 1) == 1) v = raw - (longint'(1) << total);
        return (v + (longint'(1) << (fw - 1))) >>> fw;
    endfunction

    task automatic big_vec(input string tag, input bit m, input logic [31:0] x, input longint exp);
        @(negedge clk);
        b_mode = m;
        b_in   = x;
        @(negedge clk);
        check(tag, longint'($signed(b_out)), exp, $sformatf("mode=%0d in=%h", m, x));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: registered outputs held at zero during reset, despite nonzero inputs.
        b_in = 32'h0000_0A80;
        s_in = 8'h35;
        repeat (3) @(negedge clk);
        check("R9", longint'($signed(b_out)), 0, "reset big");
        check("R9", longint'($signed(s_reg)), 0, "reset small");
        rst_n = 1'b1;

        // Default layout corners.
        big_vec("R1", 1'b0, 32'h0000_1200, 18);
        big_vec("R5", 1'b0, 32'h0000_0A00, 10);
        big_vec("R4", 1'b0, 32'h0000_0A7F, 10);
        big_vec("R4", 1'b0, 32'h0000_0A80, 11);
        big_vec("R4", 1'b0, 32'h0000_0AFF, 11);
        big_vec("R2", 1'b0, 32'h0000_0000, 0);
        big_vec("R2", 1'b0, 32'hFFFF_FF80, 16777216);
        big_vec("R6", 1'b0, 32'hFFFF_FFFF, 16777216);
        big_vec("R7", 1'b1, 32'hFFFF_FF80, 0);
        big_vec("R4", 1'b1, 32'hFFFF_FF7F, -1);
        big_vec("R4", 1'b1, 32'hFFFF_FE80, -1);
        big_vec("R4", 1'b1, 32'hFFFF_FE7F, -2);
        big_vec("R3", 1'b1, 32'hFFFF_FFFF, 0);
        big_vec("R5", 1'b1, 32'hFFFF_FF00, -1);
        big_vec("R7", 1'b1, 32'h8000_0000, -8388608);
        big_vec("R7", 1'b1, 32'h7FFF_FFFF, 8388608);
        big_vec("R3", 1'b1, 32'h0000_0A80, 11);

        // Exhaustive sweep of the small layout, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int x = 0; x < (1 << S_IN); x++) begin
                longint exp;
                string tag;
                @(negedge clk);
                s_mode = m[0];
                s_in   = x[S_IN-1:0];
                exp = model(longint'(x), m[0], S_IN, S_FRAC);
                if ((x & ((1 << S_FRAC) - 1)) == 0) tag = "R5";
                else if ((x & ((1 << S_FRAC) - 1)) >= (1 << (S_FRAC - 1))) tag = "R4";
                else if (m == 0) tag = "R2";
                else tag = "R3";
                #1;
                // R8: combinational variant shows the result in the same cycle.
                check(tag, longint'($signed(s_comb)), exp, $sformatf("comb mode=%0d in=%h", m, x));
                @(negedge clk);
                // R8: registered variant shows it one clock later.
                check("R8", longint'($signed(s_reg)), exp, $sformatf("reg mode=%0d in=%h", m, x));
            end
        end

        finish_run();
    end

endmodule